// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache

This block is a read-only cache that holds one 32-bit word per line. It is organised as 256 sets of four ways each. A request carries a 32-bit byte address. The low two bits select a byte within the word and are not used for lookup. The next eight bits select a set. The upper 22 bits are the tag. All four ways of the chosen set are read in the same cycle and their tags are compared side by side. A one-hot match vector then steers the hit word to the response.

When no way matches, the cache issues one word-aligned fill request on a simple memory port. It holds off new requests until the word comes back. It then writes that word into a victim way and returns it as the response. An empty way in the set is always used first. When every way of the set is occupied, the two low bits of a free-running 8-bit linear feedback shift register pick the victim. Only one fill is ever in flight.

Top module: `sa4_cache`

## Requirements
- R1: Address bits [1:0] are ignored for lookup, bits [9:2] pick one of 256 sets, and bits [31:10] are the 22-bit tag; addresses differing only in bits [1:0] hit the same line, and a different tag in the same set misses.
- R2: After reset every line is invalid, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R3: A request accepted (`req_valid` and `req_ready` high at a clock edge) that hits produces `rsp_valid`=1, `rsp_hit`=1 and the stored word on the cycle after acceptance.
- R4: A request that misses raises `mem_req_valid` on the next cycle with `mem_req_addr` = {tag, set, 2'b00}. The address stays stable and `req_ready` stays 0 until `mem_rsp_valid` is seen.
- R5: The cycle after `mem_rsp_valid` is sampled during a fill, the block gives `rsp_valid`=1, `rsp_hit`=0 and `rsp_data` equal to the returned word, and the line then hits.
- R6: Four different tags in one set can all be resident at the same time, and at most one way ever matches.
- R7: A miss in a set that still has an invalid way fills the lowest-numbered invalid way, so no valid line is evicted.
- R8: A miss in a full set replaces exactly one way, chosen by the two low bits of an 8-bit LFSR (taps 8,6,5,4) that steps every cycle. The new line then hits, and exactly one older line is lost.
- R9: Only one fill is outstanding. A request presented during a fill is not accepted until the fill completes, and it then sees the newly written line.
- R10: Sets are independent: filling a line in one set leaves the lines of all other sets untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all valid bits |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_addr | input | 32 | Byte address of the read |
| rsp_valid | output | 1 | Response word valid (one-cycle pulse) |
| rsp_hit | output | 1 | 1 if the response came from a hit, 0 if from a fill |
| rsp_data | output | 32 | Response word |
| mem_req_valid | output | 1 | Fill request outstanding |
| mem_req_addr | output | 32 | Word-aligned fill address |
| mem_rsp_valid | input | 1 | Fill word present |
| mem_rsp_data | input | 32 | Fill word |

## Verification
Two events can fall in the same cycle. The first is the end of a fill, which writes a way and sends the miss response. The second is a waiting request that becomes acceptable in the very next cycle. The bench provokes this by keeping `req_valid` high with a second address to the same word while a miss is in flight. It judges the outcome in two steps. First, `req_ready` must stay low for the whole fill and only one fill may be counted. Second, the miss response must be followed at once by a hit response carrying the word that was just written.

// File: rtl/sa4_cache_pkg.sv
package sa4_cache_pkg;

  localparam int unsigned RND_BITS = 8;

  typedef enum logic [0:0] {
    ST_LOOKUP = 1'b0,
    ST_FILL   = 1'b1
  } cache_state_e;

  // maximal-length step, polynomial x^8 + x^6 + x^5 + x^4 + 1
  function automatic logic [RND_BITS-1:0] rnd_step(input logic [RND_BITS-1:0] q);
    return {q[RND_BITS-2:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
  endfunction

endpackage

// File: rtl/sa4_lfsr.sv
module sa4_lfsr
  import sa4_cache_pkg::*;
#(
  parameter logic [RND_BITS-1:0] SEED = 8'h01
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [RND_BITS-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= rnd_step(q);
  end

endmodule

// File: rtl/sa4_way.sv
module sa4_way #(
  parameter int unsigned SET_W  = 8,
  parameter int unsigned TAG_W  = 22,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic              match,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int unsigned SETS = 1 << SET_W;

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q <= '0;
    else if (wr_en) vld_q[wr_set] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set] <= wr_tag;
      dat_q[wr_set] <= wr_data;
    end
  end

  assign valid_o = vld_q[rd_set];
  assign match   = valid_o && (tag_q[rd_set] == rd_tag);
  assign data_o  = dat_q[rd_set];

endmodule

// File: rtl/sa4_victim.sv
module sa4_victim #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned WAY_W = 2
) (
  input  logic [WAYS-1:0]  valid_vec,
  input  logic [WAY_W-1:0] rnd,
  output logic [WAY_W-1:0] way,
  output logic             any_free
);

  // lowest-numbered empty way wins, else the random pick
  always_comb begin
    way      = rnd;
    any_free = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        way      = WAY_W'(i);
        any_free = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sa4_cache.sv
module sa4_cache
  import sa4_cache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned SET_W  = 8,
  parameter int unsigned WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  localparam int unsigned TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  // named internal events for the checker
  logic              acc, acc_hit, acc_miss, fill_done;
  logic              any_free, victim_free;
  logic [WAYS-1:0]   hit_vec, valid_vec, wr_vec;
  logic [WAY_W-1:0]  victim_way;
  logic [DATA_W-1:0] hit_word;
  logic [DATA_W-1:0] data_vec [WAYS];

  cache_state_e      st_q;
  logic [SET_W-1:0]  fill_set_q;
  logic [TAG_W-1:0]  fill_tag_q;
  logic [WAY_W-1:0]  fill_way_q;
  logic              rsp_valid_q, rsp_hit_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [RND_BITS-1:0] rnd_q;

  logic unused_bits;
  assign unused_bits = ^{req_addr[OFF_W-1:0], rnd_q[RND_BITS-1:WAY_W]};

  sa4_lfsr u_rnd (
    .clk  (clk),
    .rst_n(rst_n),
    .q    (rnd_q)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign wr_vec[w] = fill_done && (fill_way_q == WAY_W'(w));
    sa4_way #(
      .SET_W (SET_W),
      .TAG_W (TAG_W),
      .DATA_W(DATA_W)
    ) u_way (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_set (set_of(req_addr)),
      .rd_tag (tag_of(req_addr)),
      .wr_en  (wr_vec[w]),
      .wr_set (fill_set_q),
      .wr_tag (fill_tag_q),
      .wr_data(mem_rsp_data),
      .match  (hit_vec[w]),
      .valid_o(valid_vec[w]),
      .data_o (data_vec[w])
    );
  end

  sa4_victim #(
    .WAYS (WAYS),
    .WAY_W(WAY_W)
  ) u_victim (
    .valid_vec(valid_vec),
    .rnd      (rnd_q[WAY_W-1:0]),
    .way      (victim_way),
    .any_free (any_free)
  );

  // one-hot select of the matching way
  always_comb begin
    hit_word = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_word = hit_word | data_vec[w];
    end
  end

  assign req_ready   = (st_q == ST_LOOKUP);
  assign acc         = req_valid && req_ready;
  assign acc_hit     = acc && (|hit_vec);
  assign acc_miss    = acc && !(|hit_vec);
  assign fill_done   = (st_q == ST_FILL) && mem_rsp_valid;
  assign victim_free = !valid_vec[victim_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_LOOKUP;
      fill_set_q  <= '0;
      fill_tag_q  <= '0;
      fill_way_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= acc_hit || fill_done;
      rsp_hit_q   <= acc_hit;
      if (acc_hit)        rsp_data_q <= hit_word;
      else if (fill_done) rsp_data_q <= mem_rsp_data;
      if (acc_miss) begin
        st_q       <= ST_FILL;
        fill_set_q <= set_of(req_addr);
        fill_tag_q <= tag_of(req_addr);
        fill_way_q <= victim_way;
      end else if (fill_done) begin
        st_q <= ST_LOOKUP;
      end
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_hit       = rsp_hit_q;
  assign rsp_data      = rsp_data_q;
  assign mem_req_valid = (st_q == ST_FILL);
  assign mem_req_addr  = {fill_tag_q, fill_set_q, {OFF_W{1'b0}}};

endmodule

// File: rtl/sa4_cache_chk.sv
module sa4_cache_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WAYS   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [DATA_W-1:0] mem_rsp_data,
  input logic              acc_hit,
  input logic              acc_miss,
  input logic              fill_done,
  input logic              any_free,
  input logic              victim_free,
  input logic [WAYS-1:0]   hit_vec,
  input logic [WAYS-1:0]   wr_vec
);

  // R4
  fill_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R4
  fill_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R3
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> (rsp_valid && rsp_hit));

  // R5
  fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (rsp_valid && !rsp_hit && rsp_data == $past(mem_rsp_data)));

  // R6
  one_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R7
  free_way_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_miss && any_free) |-> victim_free);

  // R8
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  // R9
  miss_starts_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss |=> (mem_req_valid && !req_ready));

endmodule

bind sa4_cache sa4_cache_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .WAYS  (WAYS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_data     (rsp_data),
  .mem_req_valid(mem_req_valid),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_data (mem_rsp_data),
  .acc_hit      (acc_hit),
  .acc_miss     (acc_miss),
  .fill_done    (fill_done),
  .any_free     (any_free),
  .victim_free  (victim_free),
  .hit_vec      (hit_vec),
  .wr_vec       (wr_vec)
);

// File: tb/sa4_cache_test.sv
`timescale 1ns/1ps
module sa4_cache_test;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_data;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int errors = 0;
  int checks = 0;
  int fills  = 0;

  always #5 clk = ~clk;

  sa4_cache uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_data     (rsp_data),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return {w[15:0] ^ 16'h5A3C, w[31:16] + 16'h0101};
  endfunction

  function automatic logic [31:0] mk(input logic [21:0] t, input logic [7:0] s,
                                     input logic [1:0] o);
    return {t, s, o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: answers a fill LAT cycles after it appears
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        cnt = 0;
        mem_rsp_valid = 1'b0;
      end else if (mem_rsp_valid) begin
        mem_rsp_valid = 1'b0;
      end else if (mem_req_valid) begin
        if (cnt == LAT) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(mem_req_addr);
          fills++;
          cnt = 0;
        end else begin
          cnt++;
        end
      end
    end
  end

  // one request; exp_mode 0 = must miss, 1 = must hit, 2 = either
  task automatic access(input logic [31:0] a, input int exp_mode, input string req,
                        output bit was_hit);
    int n = 0;
    bit got = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    #1 req_valid = 1'b0;
    repeat (40) begin
      @(negedge clk);
      n++;
      if (n == 1 && !rsp_valid) begin
        chk(mem_req_valid && !req_ready, "R4 fill started, ready low",
            {30'b0, mem_req_valid, req_ready}, 32'h2);
        chk(mem_req_addr == {a[31:2], 2'b00}, "R4 fill address", mem_req_addr,
            {a[31:2], 2'b00});
      end
      if (rsp_valid) begin
        got = 1;
        break;
      end
    end
    was_hit = got && rsp_hit;
    chk(got, {req, " response seen"}, 32'(got), 32'd1);
    chk(rsp_data == mem_word(a), {req, " data"}, rsp_data, mem_word(a));
    if (exp_mode != 2)
      chk(rsp_hit == exp_mode[0], {req, " hit flag"}, 32'(rsp_hit), 32'(exp_mode[0]));
    if (was_hit) chk(n == 1, "R3 hit latency", n, 1);
    else         chk(n == LAT + 2, "R5 fill latency", n, LAT + 2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R2 reset outputs",
        {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    bit h;
    int f0;
    int miss_cnt;
    logic [21:0] tg [5];

    do_reset();

    // R10/R5: fill one line in every set
    for (int s = 0; s < 256; s++)
      access(mk(22'(s * 37 + 1), 8'(s), 2'd0), 0, "R5 sweep fill", h);

    // R1/R3/R10: every set hits with varied byte offsets
    for (int s = 0; s < 256; s++)
      access(mk(22'(s * 37 + 1), 8'(s), 2'(s)), 1, "R1 R10 sweep hit", h);

    // R6/R7: three more tags in set 7 fill free ways, nothing evicted
    tg[0] = 22'(7 * 37 + 1);
    tg[1] = 22'h100; tg[2] = 22'h200; tg[3] = 22'h300; tg[4] = 22'h3FF00;
    for (int i = 1; i < 4; i++)
      access(mk(tg[i], 8'd7, 2'd0), 0, "R1 R7 same set new tag", h);
    for (int i = 0; i < 4; i++)
      access(mk(tg[i], 8'd7, 2'd3), 1, "R6 four ways resident", h);

    // R8: full set, new tag evicts exactly one way
    access(mk(tg[4], 8'd7, 2'd0), 0, "R8 full set miss", h);
    access(mk(tg[4], 8'd7, 2'd1), 1, "R8 new line hits", h);
    miss_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      access(mk(tg[i], 8'd7, 2'd0), 2, "R8 old line probe", h);
      if (!h) miss_cnt++;
    end
    chk(miss_cnt >= 1 && miss_cnt <= 2, "R8 one old line lost", miss_cnt, 1);
    access(mk(22'(8 * 37 + 1), 8'd8, 2'd2), 1, "R10 neighbour set intact", h);

    // R9: request waiting during a fill is held, then hits the new line
    begin
      logic [31:0] b;
      int n = 0;
      int held_bad = 0;
      bit got = 0;
      b = mk(22'h3AB, 8'd20, 2'd0);
      f0 = fills;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = b;
      @(posedge clk);
      #1 req_addr = b | 32'h2;
      repeat (40) begin
        @(negedge clk);
        n++;
        if (rsp_valid) begin
          got = 1;
          break;
        end
        if (req_ready) held_bad++;
      end
      chk(held_bad == 0, "R9 ready low during fill", held_bad, 0);
      chk(got && !rsp_hit && rsp_data == mem_word(b), "R9 miss response", rsp_data,
          mem_word(b));
      chk(req_ready, "R9 ready back after fill", 32'(req_ready), 32'd1);
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      chk(rsp_valid && rsp_hit && rsp_data == mem_word(b), "R9 waiting request hits",
          rsp_data, mem_word(b));
      chk(fills == f0 + 1, "R9 single fill", fills - f0, 1);
    end

    // R2: reset clears valid bits
    do_reset();
    access(mk(22'd1, 8'd0, 2'd0), 0, "R2 line invalid after reset", h);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule